// File: doc/BRIEF.md
# Cascaded Interrupt Vector Encoder

This block sits beside a pair of cascaded 8-input interrupt controllers. It merges their request and mask vectors into one 16-line view and returns a single vector byte that names the highest-priority line that is pending and not masked. A handler can then find its source with one read instead of querying both controllers. Line 2 of the first controller carries the second controller's output, so it is never reported as a source.

Reads arrive on a valid/ready request channel. The response leaves on a valid/ready channel. A read is accepted when `rd_valid` and `rd_ready` are both high at a clock edge. The line search is sampled at that edge, and the byte appears on `vec_data` with `vec_valid` in the next cycle. While `vec_valid` is high and `vec_ready` is low, the response holds still and `rd_ready` is low, so back-pressure from the consumer stalls new reads. A write strobe does not change the vector or any other state. It only raises a one-cycle warning pulse.

Top module: `irq_vector_encoder`

## Requirements
- R1: Line n is pending when its request bit is high and its mask bit is low. Lines 0 to 7 are bits 0 to 7 of `irq_req_a`/`irq_mask_a`, and lines 8 to 15 are bits 0 to 7 of `irq_req_b`/`irq_mask_b`.
- R2: When several lines are pending, the lowest line number wins.
- R3: Line 2 is never reported. If line 2 is the only pending line, the read is treated as having no source.
- R4: For a winning line n, the returned byte is 0x20 + n (0x20 to 0x2F).
- R5: When no line qualifies, the returned byte is 0x20 and `vec_spurious` is 1. When a line does qualify, `vec_spurious` is 0. `vec_spurious` is meaningful only while `vec_valid` is 1.
- R6: A high `wr_strobe` makes `wr_warn` high for exactly the next cycle. It does not change `vec_valid`, `vec_data` or `vec_spurious`.
- R7: An accepted read sets `vec_valid` in the following cycle. The byte reflects the inputs at the accepting edge, and later input changes do not alter it.
- R8: While `vec_valid` is 1 and `vec_ready` is 0, `vec_data` and `vec_spurious` stay stable, `vec_valid` stays 1 and `rd_ready` is 0.
- R9: After reset, `vec_valid`, `vec_spurious` and `wr_warn` are 0, `vec_data` is 0x00, and `rd_ready` is 1.
- R10: After a response is taken (`vec_valid` and `vec_ready` high) with no new read accepted, `vec_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_a | input | 8 | Request bits of the first controller (lines 0-7) |
| irq_mask_a | input | 8 | Mask bits of the first controller, 1 = masked |
| irq_req_b | input | 8 | Request bits of the second controller (lines 8-15) |
| irq_mask_b | input | 8 | Mask bits of the second controller, 1 = masked |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| wr_strobe | input | 1 | Write attempt to the vector register |
| wr_warn | output | 1 | One-cycle pulse after a write attempt |
| vec_valid | output | 1 | Response byte valid |
| vec_ready | input | 1 | Consumer accepts the response |
| vec_data | output | 8 | Vector byte, 0x20 + line |
| vec_spurious | output | 1 | Response carries no real source |

## Verification
Every result is due one edge after its cause. The vector byte and its spurious flag appear the cycle after the accepting edge, and `wr_warn` appears the cycle after the strobe. The bench drives inputs on the falling edge and samples on the next falling edge, which keeps it exactly one rising edge past the stimulus. For the hold cases, the bench changes the request inputs after acceptance and re-samples over several stalled cycles. It then releases `vec_ready` and checks that `vec_valid` falls one cycle later.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;
  localparam vec_t VEC_BASE = 8'h20;
endpackage

// File: rtl/ivec_pending.sv
module ivec_pending #(
  parameter int CTRL_LINES = 8,
  parameter int CASCADE    = 2,
  localparam int LINES     = 2 * CTRL_LINES
) (
  input  logic [CTRL_LINES-1:0] req_a,
  input  logic [CTRL_LINES-1:0] mask_a,
  input  logic [CTRL_LINES-1:0] req_b,
  input  logic [CTRL_LINES-1:0] mask_b,
  output logic [LINES-1:0]      pend
);
  logic [LINES-1:0] raw;

  assign raw = {req_b & ~mask_b, req_a & ~mask_a};

  // The cascade input is never a source of its own.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == CASCADE) begin : g_casc
      assign pend[i] = 1'b0;
    end else begin : g_norm
      assign pend[i] = raw[i];
    end
  end
endmodule

// File: rtl/ivec_search.sv
module ivec_search #(
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pend,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  logic [LINES:0]   seen;
  logic [LINES-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < LINES; i++) begin : g_chain
    assign grant[i]  = pend[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pend[i];
  end
  assign found = seen[LINES];

  always_comb begin
    idx = '0;
    for (int i = 0; i < LINES; i++)
      if (grant[i]) idx = idx | IDX_W'(i);
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> pend[idx]); // R1
endmodule

// File: rtl/ivec_resp.sv
module ivec_resp #(
  parameter int IDX_W   = 4,
  parameter int CASCADE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              found,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              vec_ready,
  output logic              vec_valid,
  output ivec_pkg::vec_t    vec_data,
  output logic              vec_spurious
);
  import ivec_pkg::*;

  logic accept;
  vec_t next_vec;

  assign rd_ready = !vec_valid || vec_ready;
  assign accept   = rd_valid && rd_ready;
  assign next_vec = found ? vec_t'(VEC_BASE + vec_t'(idx)) : VEC_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid    <= 1'b0;
      vec_data     <= '0;
      vec_spurious <= 1'b0;
    end else if (accept) begin
      vec_valid    <= 1'b1;
      vec_data     <= next_vec;
      vec_spurious <= !found;
    end else if (vec_valid && vec_ready) begin
      vec_valid    <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_data) && $stable(vec_spurious)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |-> !rd_ready); // R8
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> vec_valid); // R7
  AST_SPUR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_spurious |-> vec_data == VEC_BASE); // R5
  AST_NO_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_data != vec_t'(VEC_BASE + vec_t'(CASCADE))); // R3
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready && !rd_valid |=> !vec_valid); // R10
endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder #(
  parameter int CTRL_LINES = 8,
  parameter int CASCADE    = 2,
  localparam int LINES     = 2 * CTRL_LINES,
  localparam int IDX_W     = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CTRL_LINES-1:0] irq_req_a,
  input  logic [CTRL_LINES-1:0] irq_mask_a,
  input  logic [CTRL_LINES-1:0] irq_req_b,
  input  logic [CTRL_LINES-1:0] irq_mask_b,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic                  wr_strobe,
  output logic                  wr_warn,
  output logic                  vec_valid,
  input  logic                  vec_ready,
  output logic [7:0]            vec_data,
  output logic                  vec_spurious
);
  logic [LINES-1:0] pend;
  logic [IDX_W-1:0] idx;
  logic             found;

  ivec_pending #(.CTRL_LINES(CTRL_LINES), .CASCADE(CASCADE)) u_pend (
    .req_a(irq_req_a), .mask_a(irq_mask_a),
    .req_b(irq_req_b), .mask_b(irq_mask_b),
    .pend(pend)
  );

  ivec_search #(.LINES(LINES)) u_search (
    .clk(clk), .rst_n(rst_n), .pend(pend), .idx(idx), .found(found)
  );

  ivec_resp #(.IDX_W(IDX_W), .CASCADE(CASCADE)) u_resp (
    .clk(clk), .rst_n(rst_n), .idx(idx), .found(found),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .vec_ready(vec_ready), .vec_valid(vec_valid),
    .vec_data(vec_data), .vec_spurious(vec_spurious)
  );

  // Writes are not stored; they only raise a warning pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) wr_warn <= 1'b0;
    else        wr_warn <= wr_strobe;
  end

  AST_WARN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> wr_warn); // R6
  AST_WARN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> !wr_warn); // R6
endmodule

// File: tb/sim_irq_vector_encoder.sv
`timescale 1ns/1ps
module sim_irq_vector_encoder;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] req_a, mask_a, req_b, mask_b;
  logic rd_valid, rd_ready, wr_strobe, wr_warn;
  logic vec_valid, vec_ready, vec_spurious;
  logic [7:0] vec_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_vector_encoder u0 (
    .clk(clk), .rst_n(rst_n),
    .irq_req_a(req_a), .irq_mask_a(mask_a),
    .irq_req_b(req_b), .irq_mask_b(mask_b),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_strobe(wr_strobe), .wr_warn(wr_warn),
    .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .vec_spurious(vec_spurious)
  );

  // {req_a, mask_a, req_b, mask_b, expected byte, expected spurious}
  localparam int NV = 11;
  localparam logic [40:0] TBL [NV] = '{
    {8'h01, 8'h00, 8'h00, 8'h00, 8'h20, 1'b0},  // R4 line 0
    {8'h02, 8'h00, 8'h00, 8'h00, 8'h21, 1'b0},  // R4 line 1
    {8'h04, 8'h00, 8'h00, 8'h00, 8'h20, 1'b1},  // R3 only cascade
    {8'h0C, 8'h00, 8'h00, 8'h00, 8'h23, 1'b0},  // R3 cascade skipped
    {8'hFF, 8'hFF, 8'h01, 8'h00, 8'h28, 1'b0},  // R1 masked low half
    {8'h00, 8'h00, 8'h80, 8'h00, 8'h2F, 1'b0},  // R4 line 15
    {8'h80, 8'h00, 8'h01, 8'h00, 8'h27, 1'b0},  // R2 7 beats 8
    {8'hF0, 8'hF0, 8'hF0, 8'h30, 8'h2E, 1'b0},  // R1 masks both halves
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 1'b1},  // R5 nothing
    {8'h06, 8'h02, 8'h04, 8'h00, 8'h2A, 1'b0},  // R3 mask + cascade
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h20, 1'b0}   // R2 all pending
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_a = 0; mask_a = 0; req_b = 0; mask_b = 0;
    rd_valid = 0; wr_strobe = 0; vec_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 vec_valid", {7'd0, vec_valid}, 8'd0);
    chk("R9 vec_data", vec_data, 8'h00);
    chk("R9 vec_spurious", {7'd0, vec_spurious}, 8'd0);
    chk("R9 wr_warn", {7'd0, wr_warn}, 8'd0);
    chk("R9 rd_ready", {7'd0, rd_ready}, 8'd1);

    for (int k = 0; k < NV; k++) begin
      {req_a, mask_a, req_b, mask_b} = TBL[k][40:9];
      rd_valid = 1'b1;
      tick();
      rd_valid = 1'b0;
      chk("R7 vec_valid", {7'd0, vec_valid}, 8'd1);
      chk("R4 vec_data", vec_data, TBL[k][8:1]);
      chk("R5 vec_spurious", {7'd0, vec_spurious}, {7'd0, TBL[k][0]});
      tick();
      chk("R10 drained", {7'd0, vec_valid}, 8'd0);
    end

    // R6: write has no effect but the warning
    req_a = 8'h08; mask_a = 0; req_b = 0; mask_b = 0;
    wr_strobe = 1'b1;
    tick();
    wr_strobe = 1'b0;
    chk("R6 wr_warn high", {7'd0, wr_warn}, 8'd1);
    chk("R6 vec_valid untouched", {7'd0, vec_valid}, 8'd0);
    chk("R6 vec_data untouched", vec_data, 8'h20);
    tick();
    chk("R6 wr_warn one cycle", {7'd0, wr_warn}, 8'd0);

    // R7/R8: stall holds the sampled byte
    vec_ready = 1'b0;
    req_a = 8'h20;
    rd_valid = 1'b1;
    tick();
    rd_valid = 1'b0;
    req_a = 8'h01;
    chk("R7 sampled byte", vec_data, 8'h25);
    for (int s = 0; s < 3; s++) begin
      wr_strobe = 1'b1;
      tick();
      chk("R8 held data", vec_data, 8'h25);
      chk("R8 held valid", {7'd0, vec_valid}, 8'd1);
      chk("R8 rd_ready low", {7'd0, rd_ready}, 8'd0);
    end
    wr_strobe = 1'b0;
    rd_valid = 1'b1;
    tick();
    chk("R8 stalled read ignored", vec_data, 8'h25);
    vec_ready = 1'b1;
    tick();
    rd_valid = 1'b0;
    chk("R8 queued read accepted", vec_data, 8'h20);
    chk("R5 real source", {7'd0, vec_spurious}, 8'd0);
    tick();
    chk("R10 drained after stall", {7'd0, vec_valid}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule